// File: doc/BRIEF.md
# Lockable Serial Number Register Bank

This block holds an eight-byte identification value that system software writes through byte-framed serial commands. A transaction starts when the active-low select falls; the first byte received is a command code and any further bytes are its data. The identification bytes are loaded by a burst write that is gated by a write-enable latch and by a write-once lock flag held in a status byte. The bytes carry no checksum logic; whatever is written is kept as given.

Each byte and the lock flag exist twice: a working (volatile) copy and a saved (non-volatile) copy. A save command copies working to saved. A power-cycle pulse reloads the working copies from the saved ones, so a lock that was set but never saved disappears together with unsaved bytes, while a saved lock is permanent. With the automatic-save input high, a power cycle first saves and then reloads, so nothing is lost. A combinational read port returns any working byte.

Top module: `snBank`

## Requirements
- R1: After reset all eight working bytes read 0x00, and the lock flag and the write-enable latch read 0; the saved copies are also zero.
- R2: Command 0x06 sets the write-enable latch and command 0x04 clears it, each taking effect on the clock edge that samples select high after the command; select low never changes the latch except through a power cycle.
- R3: Command 0xC2 issued with the latch set writes the following data bytes into byte 0, 1, 2 and so on in order; the latch clears when select rises.
- R4: Command 0xC2 issued with the latch clear changes no byte.
- R5: A burst of more than eight data bytes wraps its index from 7 back to 0, so the ninth byte overwrites byte 0.
- R6: Command 0x01 issued with the latch set takes one data byte; bit 6 of it at 1 sets the lock flag, at 0 leaves it unchanged; the latch clears when select rises.
- R7: While the lock flag is 1, command 0xC2 changes no byte, yet still clears the latch at select rise.
- R8: A power-cycle pulse with automatic save low reloads the working bytes and lock from the saved copies and clears the latch; a lock and bytes never saved return to 0.
- R9: Command 0x3C copies the working bytes and lock into the saved copies at select rise, so they survive a later power cycle.
- R10: A saved lock of 1 is never cleared by any command or power cycle.
- R11: A power-cycle pulse with automatic save high saves the working copies first, so the working bytes and lock are unchanged afterwards.
- R12: A power-cycle pulse during a transaction aborts it: later data bytes in the same select-low period are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset, clears all copies |
| csN | input | 1 | Active-low transaction select |
| rxValid | input | 1 | A received byte is present this cycle |
| rxByte | input | 8 | Received byte (command or data) |
| powerCycle | input | 1 | One-cycle power-cycle event |
| autoStoreEn | input | 1 | Save working copies before a power-cycle reload |
| rdAddr | input | 3 | Working byte index to read |
| rdData | output | 8 | Working byte at rdAddr |
| lockOut | output | 1 | Working lock flag |
| wenOut | output | 1 | Write-enable latch |

## Verification
The bench aims at the wrap of a long burst, where a design that saturated or stopped at byte 7 would leave byte 0 with its first value. It sets the lock without saving and then power-cycles, which catches a design that treats any set lock as permanent or forgets to zero unsaved bytes; it then saves the lock and tries to clear it, which catches a lock that is writable after saving. It also writes while locked or without the latch, where a faulty gate would alter bytes, and pulses a power cycle mid-burst, where a design that kept its transaction state would go on writing.

// File: rtl/snPkg.sv
package snPkg;
  parameter int SN_BYTES  = 8;
  parameter int SN_BYTE_W = 8;
  localparam int SN_IDX_W = $clog2(SN_BYTES);

  localparam logic [SN_BYTE_W-1:0] OP_SET_WEN = 8'h06;
  localparam logic [SN_BYTE_W-1:0] OP_CLR_WEN = 8'h04;
  localparam logic [SN_BYTE_W-1:0] OP_WR_SN   = 8'hC2;
  localparam logic [SN_BYTE_W-1:0] OP_WR_STAT = 8'h01;
  localparam logic [SN_BYTE_W-1:0] OP_SAVE    = 8'h3C;

  typedef enum logic [2:0] {
    PH_IDLE, PH_OPCODE, PH_SNDATA, PH_STATDATA, PH_HOLD
  } phaseT;

  typedef enum logic [1:0] {
    PD_NONE, PD_SETWEN, PD_CLRWEN, PD_SAVE
  } pendT;

  typedef struct packed {
    logic                 setWen;
    logic                 clrWen;
    logic                 wrByte;
    logic [SN_IDX_W-1:0]  wrIdx;
    logic [SN_BYTE_W-1:0] wrData;
    logic                 setLock;
    logic                 save;
    logic                 reload;
    logic                 saveFirst;
  } snStrobeT;
endpackage

// File: rtl/snCtrl.sv
module snCtrl
  import snPkg::*;
#(
  parameter int LOCK_BIT = 6
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 csN,
  input  logic                 rxValid,
  input  logic [SN_BYTE_W-1:0] rxByte,
  input  logic                 powerCycle,
  input  logic                 autoStoreEn,
  input  logic                 wenNow,
  input  logic                 lockNow,
  output snStrobeT             strobe
);
  logic                csPrev;
  logic                csFall;
  logic                csRise;
  phaseT               phase, phaseNxt, curPh;
  pendT                pend, pendNxt;
  logic [SN_IDX_W-1:0] idx, idxNxt;

  assign csFall = csPrev & ~csN;
  assign csRise = ~csPrev & csN;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      csPrev <= 1'b1;
      phase  <= PH_IDLE;
      pend   <= PD_NONE;
      idx    <= '0;
    end else begin
      csPrev <= csN;
      phase  <= phaseNxt;
      pend   <= pendNxt;
      idx    <= idxNxt;
    end
  end

  always_comb begin
    strobe   = '0;
    phaseNxt = phase;
    pendNxt  = pend;
    idxNxt   = idx;
    curPh    = csFall ? PH_OPCODE : phase;
    if (powerCycle) begin
      strobe.reload    = 1'b1;
      strobe.saveFirst = autoStoreEn;
      phaseNxt         = PH_IDLE;
      pendNxt          = PD_NONE;
    end else if (csRise) begin
      unique case (pend)
        PD_SETWEN: strobe.setWen = 1'b1;
        PD_CLRWEN: strobe.clrWen = 1'b1;
        PD_SAVE:   strobe.save   = 1'b1;
        default:   ;
      endcase
      phaseNxt = PH_IDLE;
      pendNxt  = PD_NONE;
    end else if (!csN) begin
      phaseNxt = curPh;
      if (csFall) pendNxt = PD_NONE;
      if (rxValid) begin
        unique case (curPh)
          PH_OPCODE: begin
            phaseNxt = PH_HOLD;
            case (rxByte)
              OP_SET_WEN: pendNxt = PD_SETWEN;
              OP_CLR_WEN: pendNxt = PD_CLRWEN;
              OP_SAVE:    pendNxt = PD_SAVE;
              OP_WR_SN: begin
                if (wenNow) begin
                  phaseNxt = PH_SNDATA;
                  pendNxt  = PD_CLRWEN;
                  idxNxt   = '0;
                end
              end
              OP_WR_STAT: begin
                if (wenNow) begin
                  phaseNxt = PH_STATDATA;
                  pendNxt  = PD_CLRWEN;
                end
              end
              default: ;
            endcase
          end
          PH_SNDATA: begin
            strobe.wrByte = ~lockNow;
            strobe.wrIdx  = idx;
            strobe.wrData = rxByte;
            idxNxt        = idx + 1'b1;
          end
          PH_STATDATA: begin
            strobe.setLock = rxByte[LOCK_BIT];
            phaseNxt       = PH_HOLD;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/snDatapath.sv
module snDatapath
  import snPkg::*;
(
  input  logic                          clk,
  input  logic                          rstN,
  input  snStrobeT                      strobe,
  input  logic [SN_IDX_W-1:0]           rdAddr,
  output logic [SN_BYTE_W-1:0]          rdData,
  output logic                          lockVol,
  output logic                          lockSaved,
  output logic                          wen,
  output logic [SN_BYTES*SN_BYTE_W-1:0] volFlat
);
  logic [SN_BYTE_W-1:0] volMem [SN_BYTES];
  logic [SN_BYTE_W-1:0] savMem [SN_BYTES];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lockVol   <= 1'b0;
      lockSaved <= 1'b0;
      wen       <= 1'b0;
    end else if (strobe.reload) begin
      wen <= 1'b0;
      if (strobe.saveFirst) lockSaved <= lockSaved | lockVol;
      else                  lockVol   <= lockSaved;
    end else begin
      if (strobe.setWen)      wen <= 1'b1;
      else if (strobe.clrWen) wen <= 1'b0;
      if (strobe.setLock) lockVol   <= 1'b1;
      if (strobe.save)    lockSaved <= lockSaved | lockVol;
    end
  end

  for (genvar g = 0; g < SN_BYTES; g++) begin : gByte
    always_ff @(posedge clk) begin
      if (!rstN) begin
        volMem[g] <= '0;
        savMem[g] <= '0;
      end else if (strobe.reload) begin
        if (strobe.saveFirst) savMem[g] <= volMem[g];
        else                  volMem[g] <= savMem[g];
      end else begin
        if (strobe.wrByte && strobe.wrIdx == SN_IDX_W'(g)) volMem[g] <= strobe.wrData;
        if (strobe.save) savMem[g] <= volMem[g];
      end
    end
    assign volFlat[g*SN_BYTE_W +: SN_BYTE_W] = volMem[g];
  end

  assign rdData = volMem[rdAddr];
endmodule

// File: rtl/snBank.sv
module snBank
  import snPkg::*;
#(
  parameter int LOCK_BIT = 6
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 csN,
  input  logic                 rxValid,
  input  logic [SN_BYTE_W-1:0] rxByte,
  input  logic                 powerCycle,
  input  logic                 autoStoreEn,
  input  logic [SN_IDX_W-1:0]  rdAddr,
  output logic [SN_BYTE_W-1:0] rdData,
  output logic                 lockOut,
  output logic                 wenOut
);
  snStrobeT                      strobe;
  logic                          lockSaved;
  logic [SN_BYTES*SN_BYTE_W-1:0] volFlat;

  snCtrl #(.LOCK_BIT(LOCK_BIT)) ctrlI (
    .clk(clk), .rstN(rstN), .csN(csN), .rxValid(rxValid), .rxByte(rxByte),
    .powerCycle(powerCycle), .autoStoreEn(autoStoreEn),
    .wenNow(wenOut), .lockNow(lockOut), .strobe(strobe)
  );

  snDatapath dpI (
    .clk(clk), .rstN(rstN), .strobe(strobe), .rdAddr(rdAddr), .rdData(rdData),
    .lockVol(lockOut), .lockSaved(lockSaved), .wen(wenOut), .volFlat(volFlat)
  );
endmodule

// File: rtl/snBankChk.sv
module snBankChk
  import snPkg::*;
(
  input logic                          clk,
  input logic                          rstN,
  input logic                          csN,
  input logic                          powerCycle,
  input logic                          autoStoreEn,
  input logic                          lockOut,
  input logic                          wenOut,
  input logic                          lockSaved,
  input logic [SN_BYTES*SN_BYTE_W-1:0] volFlat
);
  // R10
  saved_lock_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    lockSaved |=> lockSaved);

  // R7
  locked_bytes_frozen_chk: assert property (@(posedge clk) disable iff (!rstN)
    (lockOut && !powerCycle) |=> $stable(volFlat));

  // R4
  no_wen_no_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!wenOut && !powerCycle) |=> $stable(volFlat));

  // R8
  reload_lock_chk: assert property (@(posedge clk) disable iff (!rstN)
    (powerCycle && !autoStoreEn) |=> (lockOut == $past(lockSaved)));

  // R2
  wen_quiet_while_selected_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!csN && !powerCycle) |=> $stable(wenOut));

  // R11
  autosave_keeps_bytes_chk: assert property (@(posedge clk) disable iff (!rstN)
    (powerCycle && autoStoreEn) |=> ($stable(volFlat) && $stable(lockOut)));
endmodule

bind snBank snBankChk chkI (
  .clk(clk), .rstN(rstN), .csN(csN), .powerCycle(powerCycle),
  .autoStoreEn(autoStoreEn), .lockOut(lockOut), .wenOut(wenOut),
  .lockSaved(lockSaved), .volFlat(volFlat)
);

// File: tb/snBank_tb_top.sv
module snBank_tb_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       csN = 1'b1;
  logic       rxValid = 1'b0;
  logic [7:0] rxByte = '0;
  logic       powerCycle = 1'b0;
  logic       autoStoreEn = 1'b0;
  logic [2:0] rdAddr = '0;
  logic [7:0] rdData;
  logic       lockOut;
  logic       wenOut;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  snBank dut_i (
    .clk(clk), .rstN(rstN), .csN(csN), .rxValid(rxValid), .rxByte(rxByte),
    .powerCycle(powerCycle), .autoStoreEn(autoStoreEn), .rdAddr(rdAddr),
    .rdData(rdData), .lockOut(lockOut), .wenOut(wenOut)
  );

  task automatic checkVal(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic checkBytes(string tag, logic [7:0] exp [8]);
    for (int i = 0; i < 8; i++) begin
      rdAddr = 3'(i);
      #1;
      checkVal($sformatf("%s byte%0d", tag, i), int'(rdData), int'(exp[i]));
    end
  endtask

  task automatic doReset();
    @(negedge clk); rstN = 1'b0;
    @(negedge clk); @(negedge clk); rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic sendByte(logic [7:0] b);
    @(negedge clk); rxValid = 1'b1; rxByte = b;
    @(negedge clk); rxValid = 1'b0;
  endtask

  task automatic selLow();
    @(negedge clk); csN = 1'b0;
  endtask

  task automatic selHigh();
    @(negedge clk); csN = 1'b1;
    @(negedge clk);
  endtask

  task automatic cmd(logic [7:0] op);
    selLow(); sendByte(op); selHigh();
  endtask

  task automatic writeSn(logic [7:0] data [], int n);
    selLow(); sendByte(8'hC2);
    for (int i = 0; i < n; i++) sendByte(data[i]);
    selHigh();
  endtask

  task automatic writeStat(logic [7:0] v);
    selLow(); sendByte(8'h01); sendByte(v); selHigh();
  endtask

  task automatic pulsePower(logic autoSave);
    @(negedge clk); autoStoreEn = autoSave; powerCycle = 1'b1;
    @(negedge clk); powerCycle = 1'b0; autoStoreEn = 1'b0;
  endtask

  logic [7:0] zeros [8] = '{default: 8'h00};
  logic [7:0] patA [8] = '{8'h11, 8'h22, 8'h33, 8'h44, 8'h55, 8'h66, 8'h77, 8'h88};
  logic [7:0] patQ [8] = '{8'hFF, 8'h00, 8'h5A, 8'hA5, 8'h01, 8'h80, 8'hC3, 8'h3C};

  task automatic testReset();
    doReset();
    checkBytes("R1 reset", zeros);
    checkVal("R1 lock", int'(lockOut), 0);
    checkVal("R1 wen", int'(wenOut), 0);
  endtask

  task automatic testNoWen();
    logic [7:0] d [] = '{8'hDE, 8'hAD};
    writeSn(d, 2);
    checkBytes("R4 write without wen", zeros);
    cmd(8'h06);
    checkVal("R2 wen set", int'(wenOut), 1);
    cmd(8'h04);
    checkVal("R2 wen cleared", int'(wenOut), 0);
  endtask

  task automatic testBurst();
    logic [7:0] d [] = new[8];
    for (int i = 0; i < 8; i++) d[i] = patA[i];
    cmd(8'h06);
    writeSn(d, 8);
    checkBytes("R3 burst", patA);
    checkVal("R3 wen cleared", int'(wenOut), 0);
  endtask

  task automatic testWrap();
    logic [7:0] d [] = new[10];
    logic [7:0] exp [8];
    for (int i = 0; i < 10; i++) d[i] = 8'hA0 + 8'(i);
    for (int i = 0; i < 8; i++) exp[i] = 8'hA0 + 8'(i);
    exp[0] = 8'hA8; exp[1] = 8'hA9;
    cmd(8'h06);
    writeSn(d, 10);
    checkBytes("R5 wrap", exp);
  endtask

  task automatic testUnsavedLock();
    logic [7:0] d [] = new[8];
    logic [7:0] d2 [] = '{8'h99, 8'h98, 8'h97};
    pulsePower(1'b0);
    checkBytes("R8 unsaved bytes revert", zeros);
    for (int i = 0; i < 8; i++) d[i] = patA[i];
    cmd(8'h06); writeSn(d, 8);
    cmd(8'h06); writeStat(8'h40);
    checkVal("R6 lock set", int'(lockOut), 1);
    checkVal("R6 wen cleared", int'(wenOut), 0);
    cmd(8'h06);
    writeSn(d2, 3);
    checkBytes("R7 locked write ignored", patA);
    checkVal("R7 wen cleared", int'(wenOut), 0);
    pulsePower(1'b0);
    checkVal("R8 unsaved lock reverts", int'(lockOut), 0);
    checkBytes("R8 bytes revert", zeros);
  endtask

  task automatic testSavedLock();
    logic [7:0] d [] = new[8];
    for (int i = 0; i < 8; i++) d[i] = patQ[i];
    cmd(8'h06); writeSn(d, 8);
    cmd(8'h06); writeStat(8'hBF);
    checkVal("R6 bit6 zero keeps lock clear", int'(lockOut), 0);
    cmd(8'h06); writeStat(8'h40);
    cmd(8'h3C);
    pulsePower(1'b0);
    checkVal("R9 saved lock survives", int'(lockOut), 1);
    checkBytes("R9 saved bytes survive", patQ);
    cmd(8'h06); writeStat(8'h00);
    checkVal("R10 lock not cleared by write", int'(lockOut), 1);
    pulsePower(1'b0);
    checkVal("R10 lock after second power cycle", int'(lockOut), 1);
  endtask

  task automatic testAutoSave();
    logic [7:0] d [] = new[8];
    doReset();
    for (int i = 0; i < 8; i++) d[i] = patA[i];
    cmd(8'h06); writeSn(d, 8);
    pulsePower(1'b1);
    checkBytes("R11 autosave keeps bytes", patA);
    pulsePower(1'b0);
    checkBytes("R11 bytes were saved", patA);
  endtask

  task automatic testAbort();
    logic [7:0] exp [8];
    for (int i = 0; i < 8; i++) exp[i] = patA[i];
    exp[0] = 8'h01; exp[1] = 8'h02;
    cmd(8'h06);
    selLow(); sendByte(8'hC2); sendByte(8'h01); sendByte(8'h02);
    pulsePower(1'b1);
    sendByte(8'h03); sendByte(8'h04);
    selHigh();
    checkBytes("R12 abort mid burst", exp);
    checkVal("R12 wen cleared", int'(wenOut), 0);
  endtask

  initial begin
    testReset();
    testNoWen();
    testBurst();
    testWrap();
    testUnsavedLock();
    testSavedLock();
    testAutoSave();
    testAbort();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule